// File: doc/BRIEF.md
# Processor Cluster Control Register Block

This block is the host-side control window for a small group of soft processor cores. A host reaches it through a 32-bit bus slave port that uses a single-cycle request strobe and returns a one-cycle acknowledge. Through this port the host can:

- read a fixed application identifier and the number of cores;
- hold or release each core's reset;
- load and read back each core's private memory;
- drain the debug characters that each core emits.

A core-select register steers one address/data pair, one debug-message register and one memory-size register to a single core. The cores themselves are not part of the block. Each core is seen only as an external synchronous memory port, with one enable per core and a shared address and write data, and as a debug push strobe with an 8-bit character. Each core has its own 16-entry character FIFO. A poll register shows which FIFOs hold data. A mask register decides which of them raise the shared debug interrupt.

A small bus state machine sequences every access. It has three states:

- **IDLE** waits for a request. On a request it performs the write or captures the read data, and takes transition *accept* into **ACK**. If the request is a read of the upload-data register for an existing core, it instead takes transition *mem_read* into **MEM_WAIT**.
- **MEM_WAIT** waits one cycle for the memory to respond. Transition *mem_done* latches that core's memory read word and moves to **ACK**.
- **ACK** drives the acknowledge for one cycle. Transition *release* returns to **IDLE**.

Top module: `cpu_cluster_ctrl`

## Requirements
- R1: After reset, every core-reset output is 1, the debug interrupt is low, word 0x00 reads the application identifier, and bits [3:0] of word 0x08 read the core count with all higher bits zero.
- R2: Writing word 0x04 sets the core-reset outputs to bits [N-1:0] of the written value. A 1 holds that core in reset and a 0 releases it. Reading word 0x04 returns the same bits.
- R3: Word 0x0C selects a core by its index. Word 0x10 returns the selected core's memory size in bytes, which is 4 × 2^MEM_AW.
- R4: After the host writes a word index to 0x14, a write to 0x18 stores the data at that index in the selected core's memory only. No other core's memory is enabled.
- R5: A read of 0x18 returns the selected core's memory word at the current index.
- R6: Bit i of word 0x1C is 1 exactly while core i's debug FIFO holds at least one character.
- R7: A read of word 0x24 returns the oldest pending character of the selected core in bits [7:0] and removes it. Characters come out in push order.
- R8: A read of 0x24 when the selected queue is empty returns zero and leaves the queue empty.
- R9: Each debug FIFO holds 16 characters. A push while the FIFO is full, with no read of that FIFO in the same cycle, is dropped.
- R10: The debug interrupt is high exactly when some core has its poll bit set and its mask bit (word 0x20, bit i) set.
- R11: The acknowledge is a one-cycle pulse. For a register access it is seen in the cycle after the request, and for a read of 0x18 it is seen two cycles after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Single-cycle access request; only accepted in IDLE |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address; bits [7:2] select the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_ack is high |
| bus_ack | output | 1 | One-cycle access acknowledge |
| core_rst | output | N_CORES | Per-core reset hold, 1 = held |
| mem_en | output | N_CORES | Per-core memory enable |
| mem_we | output | 1 | Memory write enable (shared) |
| mem_addr | output | MEM_AW | Memory word index (shared) |
| mem_wdata | output | 32 | Memory write data (shared) |
| mem_rdata | input | 32*N_CORES | Per-core memory read words, one cycle after enable |
| dbg_push | input | N_CORES | Per-core debug character push strobe |
| dbg_char | input | 8*N_CORES | Per-core debug characters |
| dbg_irq | output | 1 | Debug interrupt |

## Verification
The hardest state to reach is a debug FIFO that is exactly full while one more character arrives. The bench pushes seventeen distinct characters into one core back to back with no reads in between. It then drains that queue through the selected message register and expects exactly the first sixteen in order, followed by a zero read and a cleared poll bit. The two-cycle memory read path is timed by counting falling edges from the request to the acknowledge. The bench also compares readback against its own memory model after writes aimed at one core, and confirms that a neighbouring core's memory stayed untouched.

// File: rtl/cpuctl_pkg.sv
package cpuctl_pkg;
    localparam int WORD_W = 6;
    localparam int ADDR_W = WORD_W + 2;
    localparam int CHAR_W = 8;

    localparam logic [WORD_W-1:0] W_APPID = 6'd0;
    localparam logic [WORD_W-1:0] W_RESET = 6'd1;
    localparam logic [WORD_W-1:0] W_COUNT = 6'd2;
    localparam logic [WORD_W-1:0] W_SEL   = 6'd3;
    localparam logic [WORD_W-1:0] W_MEMSZ = 6'd4;
    localparam logic [WORD_W-1:0] W_UADDR = 6'd5;
    localparam logic [WORD_W-1:0] W_UDATA = 6'd6;
    localparam logic [WORD_W-1:0] W_POLL  = 6'd7;
    localparam logic [WORD_W-1:0] W_MASK  = 6'd8;
    localparam logic [WORD_W-1:0] W_MSG   = 6'd9;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_MEM_WAIT = 2'd1,
        ST_ACK      = 2'd2
    } bus_state_t;
endpackage

// File: rtl/cpuctl_dbg_fifo.sv
module cpuctl_dbg_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             not_empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [WIDTH-1:0] store [DEPTH];
    logic [PW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count;
    logic             push_ok, pop_ok;

    assign pop_ok  = pop && (count != '0);
    assign push_ok = push && ((count != FULL_CNT) || pop_ok);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                store[wr_ptr] <= din;
                wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop_ok)
                rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (push_ok && !pop_ok)
                count <= count + 1'b1;
            else if (pop_ok && !push_ok)
                count <= count - 1'b1;
        end
    end

    assign not_empty = (count != '0);
    assign head      = not_empty ? store[rd_ptr] : '0;

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);
    p_empty_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && count == '0) |=> (count == '0));
endmodule

// File: rtl/cpuctl_bus_fsm.sv
module cpuctl_bus_fsm
    import cpuctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic needs_mem,
    output logic idle,
    output logic ack,
    output logic cap_mem
);
    bus_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        idle     = 1'b0;
        ack      = 1'b0;
        cap_mem  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                idle = 1'b1;
                if (req) state_nx = needs_mem ? ST_MEM_WAIT : ST_ACK;
            end
            ST_MEM_WAIT: begin
                cap_mem  = 1'b1;
                state_nx = ST_ACK;
            end
            ST_ACK: begin
                ack      = 1'b1;
                state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    p_ack_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
    p_mem_wait_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MEM_WAIT) |=> ack);
endmodule

// File: rtl/cpu_cluster_ctrl.sv
module cpu_cluster_ctrl
    import cpuctl_pkg::*;
#(
    parameter int          N_CORES   = 4,
    parameter int          MEM_AW    = 6,
    parameter int          DBG_DEPTH = 16,
    parameter logic [31:0] APP_ID    = 32'hC0DE_0042
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_req,
    input  logic                    bus_we,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    output logic                    bus_ack,
    output logic [N_CORES-1:0]      core_rst,
    output logic [N_CORES-1:0]      mem_en,
    output logic                    mem_we,
    output logic [MEM_AW-1:0]       mem_addr,
    output logic [31:0]             mem_wdata,
    input  logic [32*N_CORES-1:0]   mem_rdata,
    input  logic [N_CORES-1:0]      dbg_push,
    input  logic [CHAR_W*N_CORES-1:0] dbg_char,
    output logic                    dbg_irq
);
    localparam int SEL_W = (N_CORES > 1) ? $clog2(N_CORES) : 1;
    localparam logic [31:0] MEM_BYTES = 32'((1 << MEM_AW) * 4);

    logic [WORD_W-1:0]  word;
    logic               idle, cap_mem, accept, wr, rd, sel_ok, needs_mem;
    logic [SEL_W-1:0]   sel_q;
    logic [MEM_AW-1:0]  uaddr_q;
    logic [N_CORES-1:0] rst_q, mask_q, poll, pop;
    logic [31:0]        rdata_q, rd_mux;
    logic [CHAR_W-1:0]  head [N_CORES];
    logic [31:0]        mem_word [N_CORES];

    assign word      = bus_addr[ADDR_W-1:2];
    assign sel_ok    = (32'(sel_q) < N_CORES);
    assign needs_mem = !bus_we && (word == W_UDATA) && sel_ok;
    assign accept    = idle && bus_req;
    assign wr        = accept && bus_we;
    assign rd        = accept && !bus_we;

    cpuctl_bus_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req(bus_req), .needs_mem(needs_mem),
        .idle(idle), .ack(bus_ack), .cap_mem(cap_mem)
    );

    genvar gi;
    generate
        for (gi = 0; gi < N_CORES; gi++) begin : g_core
            logic is_sel;
            assign is_sel       = sel_ok && (sel_q == SEL_W'(gi));
            assign pop[gi]      = rd && (word == W_MSG) && is_sel;
            assign mem_en[gi]   = accept && (word == W_UDATA) && is_sel;
            assign mem_word[gi] = mem_rdata[32*gi +: 32];

            cpuctl_dbg_fifo #(.DEPTH(DBG_DEPTH), .WIDTH(CHAR_W)) u_fifo (
                .clk(clk), .rst_n(rst_n),
                .push(dbg_push[gi]), .din(dbg_char[CHAR_W*gi +: CHAR_W]),
                .pop(pop[gi]), .head(head[gi]), .not_empty(poll[gi])
            );
        end
    endgenerate

    assign mem_we    = wr && (word == W_UDATA);
    assign mem_addr  = uaddr_q;
    assign mem_wdata = bus_wdata;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_q   <= '1;
            mask_q  <= '0;
            sel_q   <= '0;
            uaddr_q <= '0;
        end else if (wr) begin
            unique case (word)
                W_RESET: rst_q   <= bus_wdata[N_CORES-1:0];
                W_SEL:   sel_q   <= bus_wdata[SEL_W-1:0];
                W_UADDR: uaddr_q <= bus_wdata[MEM_AW-1:0];
                W_MASK:  mask_q  <= bus_wdata[N_CORES-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (word)
            W_APPID: rd_mux = APP_ID;
            W_RESET: rd_mux = 32'(rst_q);
            W_COUNT: rd_mux = 32'(4'(N_CORES));
            W_SEL:   rd_mux = 32'(sel_q);
            W_MEMSZ: rd_mux = MEM_BYTES;
            W_UADDR: rd_mux = 32'(uaddr_q);
            W_POLL:  rd_mux = 32'(poll);
            W_MASK:  rd_mux = 32'(mask_q);
            W_MSG:   rd_mux = sel_ok ? 32'(head[sel_q]) : '0;
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (cap_mem)
            rdata_q <= mem_word[sel_q];
        else if (rd && !needs_mem)
            rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;
    assign core_rst  = rst_q;
    assign dbg_irq   = |(poll & mask_q);

    p_rst_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && word == W_RESET) |=> (core_rst == $past(bus_wdata[N_CORES-1:0])));
    p_mask_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && word == W_MASK && bus_wdata[N_CORES-1:0] == '0) |=> !dbg_irq);
    p_mem_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mem_en));
endmodule

// File: tb/sim_cpu_cluster_ctrl.sv
module sim_cpu_cluster_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N = 4;
    localparam int AW = 6;
    localparam logic [31:0] APPID = 32'hC0DE_0042;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_req = 1'b0, bus_we = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic bus_ack, mem_we, dbg_irq;
    logic [N-1:0] core_rst, mem_en;
    logic [N-1:0] dbg_push = '0;
    logic [8*N-1:0] dbg_char = '0;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [32*N-1:0] mem_rdata;
    logic [31:0] mem [N][64];
    logic [31:0] rd_q [N];
    int checks = 0, fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpu_cluster_ctrl #(.N_CORES(N), .MEM_AW(AW), .DBG_DEPTH(16), .APP_ID(APPID)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .core_rst(core_rst), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .dbg_push(dbg_push), .dbg_char(dbg_char), .dbg_irq(dbg_irq)
    );

    always @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (!rst_n) begin
                for (int j = 0; j < 64; j++) mem[i][j] <= '0;
                rd_q[i] <= '0;
            end else if (mem_en[i]) begin
                if (mem_we) mem[i][mem_addr] <= mem_wdata;
                rd_q[i] <= mem[i][mem_addr];
            end
        end
    end
    always_comb for (int i = 0; i < N; i++) mem_rdata[32*i +: 32] = rd_q[i];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_req = 1'b0; bus_we = 1'b0;
        while (!bus_ack) @(negedge clk);
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d, output int lat);
        @(negedge clk); bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk); bus_req = 1'b0; lat = 1;
        while (!bus_ack && lat < 20) begin @(negedge clk); lat++; end
        d = bus_rdata;
    endtask

    task automatic push_char(input int core, input logic [7:0] c);
        @(negedge clk); dbg_push[core] = 1'b1; dbg_char[8*core +: 8] = c;
        @(negedge clk); dbg_push = '0;
    endtask

    task automatic t_reset_state();
        logic [31:0] d; int lat;
        chk("R1 core_rst after reset", 32'(core_rst), 32'hF);
        chk("R1 irq after reset", 32'(dbg_irq), 32'h0);
        bus_rd(8'h00, d, lat); chk("R1 app id", d, APPID);
        chk("R11 register read latency", 32'(lat), 32'd1);
        bus_rd(8'h08, d, lat); chk("R1 core count", d, 32'd4);
    endtask

    task automatic t_reset_reg();
        logic [31:0] d; int lat;
        bus_wr(8'h04, 32'hFFFF_FFF5);
        chk("R2 core_rst pins", 32'(core_rst), 32'h5);
        bus_rd(8'h04, d, lat); chk("R2 readback", d, 32'h5);
        bus_wr(8'h04, 32'h0);
        chk("R2 all released", 32'(core_rst), 32'h0);
    endtask

    task automatic t_select_memsize();
        logic [31:0] d; int lat;
        bus_wr(8'h0C, 32'd2);
        bus_rd(8'h0C, d, lat); chk("R3 select readback", d, 32'd2);
        bus_rd(8'h10, d, lat); chk("R3 memsize bytes", d, 32'd256);
    endtask

    task automatic t_upload();
        logic [31:0] d; int lat;
        bus_wr(8'h0C, 32'd2);
        bus_wr(8'h14, 32'd5);
        bus_wr(8'h18, 32'hDEAD_BEEF);
        chk("R4 selected core stored", mem[2][5], 32'hDEAD_BEEF);
        chk("R4 other core untouched", mem[1][5], 32'h0);
        bus_wr(8'h0C, 32'd1);
        bus_wr(8'h18, 32'h1111_2222);
        chk("R4 core1 stored", mem[1][5], 32'h1111_2222);
        chk("R4 core2 kept", mem[2][5], 32'hDEAD_BEEF);
        bus_rd(8'h18, d, lat); chk("R5 read core1", d, 32'h1111_2222);
        chk("R11 memory read latency", 32'(lat), 32'd2);
        bus_wr(8'h0C, 32'd2);
        bus_rd(8'h18, d, lat); chk("R5 read core2", d, 32'hDEAD_BEEF);
        bus_wr(8'h14, 32'd6);
        bus_rd(8'h18, d, lat); chk("R5 read unwritten index", d, 32'h0);
    endtask

    task automatic t_debug_irq();
        logic [31:0] d; int lat;
        push_char(1, 8'h48); push_char(1, 8'h69);
        bus_rd(8'h1C, d, lat); chk("R6 poll core1", d, 32'h2);
        chk("R10 irq masked", 32'(dbg_irq), 32'h0);
        bus_wr(8'h20, 32'h1);
        chk("R10 irq other mask", 32'(dbg_irq), 32'h0);
        bus_wr(8'h20, 32'h2);
        chk("R10 irq enabled", 32'(dbg_irq), 32'h1);
        bus_wr(8'h0C, 32'd1);
        bus_rd(8'h24, d, lat); chk("R7 first char", d, 32'h48);
        bus_rd(8'h24, d, lat); chk("R7 second char", d, 32'h69);
        bus_rd(8'h1C, d, lat); chk("R6 poll cleared", d, 32'h0);
        chk("R10 irq drops", 32'(dbg_irq), 32'h0);
        bus_rd(8'h24, d, lat); chk("R8 empty read", d, 32'h0);
        bus_rd(8'h1C, d, lat); chk("R8 still empty", d, 32'h0);
        bus_wr(8'h20, 32'h0);
    endtask

    task automatic t_overflow();
        logic [31:0] d; int lat;
        for (int i = 0; i < 17; i++) push_char(3, 8'(8'h41 + i));
        bus_rd(8'h1C, d, lat); chk("R6 poll core3", d, 32'h8);
        bus_wr(8'h0C, 32'd3);
        for (int i = 0; i < 16; i++) begin
            bus_rd(8'h24, d, lat);
            chk($sformatf("R9 drain %0d", i), d, 32'(8'h41 + i));
        end
        bus_rd(8'h24, d, lat); chk("R9 17th dropped", d, 32'h0);
        bus_rd(8'h1C, d, lat); chk("R9 poll clear", d, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        fork
            begin
                t_reset_state();
                t_reset_reg();
                t_select_memsize();
                t_upload();
                t_debug_irq();
                t_overflow();
            end
            begin
                repeat (100000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule